// File: doc/BRIEF.md
# Bit-Reversed Write Address Generator

This block computes the effective address and the pointer write-back value for one data write. It is used to store the samples of a radix-2 FFT in scrambled index order. It receives the current pointer, a 15-bit pivot, the addressing mode, the access size and the identity of the register in use. When the bit-reversed mode is armed for that register and the access qualifies, the next pointer is formed by adding the pivot with the carry running from the most significant bit towards the least significant bit (reverse-carry addition). In every other case the block produces the ordinary increment, decrement, offset or direct result. The pivot holds half the buffer length in words. It is scaled to a byte quantity by placing its bit 0 at address bit 1.

Software places the buffer on an address whose low bits are all zero, loads the pivot with half the point count and then issues post-increment word writes through the armed pointer. The pointer then steps through every word of the buffer in bit-reversed index order and wraps back to the start. While reversal is in force on a write, the block also raises a flag that tells the modulo unit to leave the address uncorrected.

Results are registered. They appear one clock after a cycle with `req` high and hold while `req` is low.

Top module: `brx_addr_gen`

## Requirements
- R1: After reset, `ea`, `ptr_nxt`, `br_act` and `mod_inh` are all zero until the first cycle with `req` high.
- R2: Reversal is active (`br_act`=1) exactly when all of the following hold: `br_en`=1, `br_sel` is not 15, `reg_idx` equals `br_sel`, `is_write`=1, `word`=1, and `mode` is post-increment (1) or pre-increment (3).
- R3: If any single condition of R2 fails (including `br_sel`=`reg_idx`=15, byte access, read access, or any other mode), `br_act`=0 and the normal results of R8/R9 are produced.
- R4: When reversal is active, `ptr_nxt` = reverse(reverse(P) + reverse(S)) over the full address width, where P is `ptr` with bit 0 cleared and S is `pivot` shifted left by one; the carry out of address bit 1 is discarded, and bit 0 of the result is 0.
- R5: When reversal is active, `ofs` has no effect on `ea` or `ptr_nxt`.
- R6: When reversal is active, bit 0 of `ea` is 0 even if `ptr` is odd.
- R7: With reversal active, post-increment gives `ea` = `ptr` with bit 0 cleared, and pre-increment gives `ea` = `ptr_nxt`.
- R8: On the normal path the step is 2 for `word`=1 and 1 for `word`=0. Post-increment (1) and post-decrement (2) give `ea`=`ptr` and `ptr_nxt`=`ptr`±step. Pre-increment (3) and pre-decrement (4) give `ea`=`ptr_nxt`=`ptr`±step. Direct mode (0) and the codes 6 and 7 give `ea`=`ptr_nxt`=`ptr`.
- R9: In offset mode (5), `ea` = `ptr`+`ofs` and `ptr_nxt` = `ptr`, so the pointer is not written back with a changed value.
- R10: `mod_inh` = `mod_en` AND `br_act`; with reversal inactive `mod_inh` is 0 regardless of `mod_en`.
- R11: From a start address with zero low bits, repeated post-increment word writes with the pivot set to half the point count visit each word of an 8-point and a 16-point buffer in bit-reversed index order and then return to the start.
- R12: Outputs reflect the inputs of the previous cycle in which `req` was high, and hold unchanged while `req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Compute and register a new result this cycle |
| is_write | input | 1 | 1 for a data write, 0 for a read |
| word | input | 1 | 1 for word access, 0 for byte access |
| mode | input | 3 | Addressing mode: 0 direct, 1 post-inc, 2 post-dec, 3 pre-inc, 4 pre-dec, 5 register plus offset |
| reg_idx | input | 4 | Index of the pointer register used by this access |
| br_en | input | 1 | Bit-reversed mode enable |
| br_sel | input | 4 | Register designated for reversal; 15 (stack pointer) never qualifies |
| mod_en | input | 1 | Modulo correction requested for this pointer |
| pivot | input | 15 | Reverse-carry modifier in words (half the buffer length) |
| ptr | input | 16 | Current pointer value (byte address) |
| ofs | input | 16 | Offset for register-plus-offset mode |
| ea | output | 16 | Effective address of the access |
| ptr_nxt | output | 16 | Value to write back to the pointer |
| br_act | output | 1 | Reversal was applied to this access |
| mod_inh | output | 1 | Modulo correction must be suppressed |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 15-bit pivot and a 4-bit register index, so 15 is the excluded stack index. This width lets the reverse-carry sum run over the whole address. Walks through 8-point and 16-point buffers at aligned bases then reach the full wrap-around. Single accesses with odd pointers, large pivots and non-zero offsets reach the LSB clearing and the rule that the offset is ignored. Each activation condition is broken one at a time to show the fallback to normal addressing.

// File: rtl/brx_pkg.sv
package brx_pkg;

  typedef enum logic [2:0] {
    AM_DIRECT   = 3'd0,
    AM_POST_INC = 3'd1,
    AM_POST_DEC = 3'd2,
    AM_PRE_INC  = 3'd3,
    AM_PRE_DEC  = 3'd4,
    AM_REG_OFS  = 3'd5
  } am_e;

  typedef struct packed {
    logic is_pre;
    logic is_inc;
    logic is_dec;
    logic is_ofs;
  } am_dec_t;

  function automatic am_dec_t am_decode(input logic [2:0] m);
    am_dec_t d;
    d = '0;
    case (m)
      AM_POST_INC: d.is_inc = 1'b1;
      AM_POST_DEC: d.is_dec = 1'b1;
      AM_PRE_INC:  begin d.is_inc = 1'b1; d.is_pre = 1'b1; end
      AM_PRE_DEC:  begin d.is_dec = 1'b1; d.is_pre = 1'b1; end
      AM_REG_OFS:  d.is_ofs = 1'b1;
      default:     d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/brx_rst_sync.sv
module brx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q_n = sh_q[STAGES-1];
endmodule

// File: rtl/brx_activate.sv
module brx_activate
  import brx_pkg::*;
#(
  parameter int SELW   = 4,
  parameter int SP_IDX = (1 << SELW) - 1
) (
  input  logic [2:0]      mode,
  input  logic [SELW-1:0] reg_idx,
  input  logic [SELW-1:0] br_sel,
  input  logic            br_en,
  input  logic            word,
  input  logic            is_write,
  output logic            act
);
  logic mode_ok;
  logic sel_ok;

  always_comb begin
    mode_ok = (mode == AM_POST_INC) || (mode == AM_PRE_INC);
    sel_ok  = (br_sel != SELW'(SP_IDX)) && (reg_idx == br_sel);
    act     = br_en && sel_ok && mode_ok && word && is_write;
  end
endmodule

// File: rtl/brx_revcarry.sv
module brx_revcarry #(
  parameter int AW = 16,
  parameter int MW = 15,
  localparam int W = AW - 1
) (
  input  logic [W-1:0]  base_hi,
  input  logic [MW-1:0] pivot,
  output logic [W-1:0]  sum_hi
);
  logic [W-1:0] piv_ext;
  logic [W-1:0] rev_a;
  logic [W-1:0] rev_b;
  logic [W-1:0] rev_s;

  always_comb begin
    piv_ext = '0;
    piv_ext[MW-1:0] = pivot;
  end

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_a[W-1-i] = base_hi[i];
    assign rev_b[W-1-i] = piv_ext[i];
    assign sum_hi[i]    = rev_s[W-1-i];
  end

  assign rev_s = rev_a + rev_b;
endmodule

// File: rtl/brx_normal.sv
module brx_normal
  import brx_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] ofs,
  input  logic [2:0]    mode,
  input  logic          word,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] nxt
);
  am_dec_t       dec;
  logic [AW-1:0] step;

  always_comb begin
    dec  = am_decode(mode);
    step = word ? AW'(2) : AW'(1);
    if (dec.is_inc)      nxt = ptr + step;
    else if (dec.is_dec) nxt = ptr - step;
    else                 nxt = ptr;
    if (dec.is_pre)      ea = nxt;
    else if (dec.is_ofs) ea = ptr + ofs;
    else                 ea = ptr;
  end
endmodule

// File: rtl/brx_addr_gen.sv
module brx_addr_gen
  import brx_pkg::*;
#(
  parameter int AW   = 16,
  parameter int MW   = 15,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic            is_write,
  input  logic            word,
  input  logic [2:0]      mode,
  input  logic [SELW-1:0] reg_idx,
  input  logic            br_en,
  input  logic [SELW-1:0] br_sel,
  input  logic            mod_en,
  input  logic [MW-1:0]   pivot,
  input  logic [AW-1:0]   ptr,
  input  logic [AW-1:0]   ofs,
  output logic [AW-1:0]   ea,
  output logic [AW-1:0]   ptr_nxt,
  output logic            br_act,
  output logic            mod_inh
);
  logic          rst_q_n;
  logic          act;
  logic [AW-2:0] rc_hi;
  logic [AW-1:0] n_ea;
  logic [AW-1:0] n_nxt;
  logic [AW-1:0] ea_d;
  logic [AW-1:0] nxt_d;
  logic          act_d;
  logic          inh_d;
  logic [AW-1:0] ea_q;
  logic [AW-1:0] nxt_q;
  logic          act_q;
  logic          inh_q;

  brx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  brx_activate #(.SELW(SELW)) u_act (
    .mode(mode), .reg_idx(reg_idx), .br_sel(br_sel), .br_en(br_en),
    .word(word), .is_write(is_write), .act(act)
  );

  brx_revcarry #(.AW(AW), .MW(MW)) u_rc (
    .base_hi(ptr[AW-1:1]), .pivot(pivot), .sum_hi(rc_hi)
  );

  brx_normal #(.AW(AW)) u_norm (
    .ptr(ptr), .ofs(ofs), .mode(mode), .word(word), .ea(n_ea), .nxt(n_nxt)
  );

  always_comb begin
    if (act) begin
      nxt_d = {rc_hi, 1'b0};
      ea_d  = (mode == AM_PRE_INC) ? {rc_hi, 1'b0} : {ptr[AW-1:1], 1'b0};
    end else begin
      nxt_d = n_nxt;
      ea_d  = n_ea;
    end
    act_d = act;
    inh_d = act && mod_en;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ea_q  <= '0;
      nxt_q <= '0;
      act_q <= 1'b0;
      inh_q <= 1'b0;
    end else if (req) begin
      ea_q  <= ea_d;
      nxt_q <= nxt_d;
      act_q <= act_d;
      inh_q <= inh_d;
    end
  end

  assign ea      = ea_q;
  assign ptr_nxt = nxt_q;
  assign br_act  = act_q;
  assign mod_inh = inh_q;
endmodule

// File: rtl/brx_addr_gen_chk.sv
module brx_addr_gen_chk #(
  parameter int AW   = 16,
  parameter int SELW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic            word,
  input logic [2:0]      mode,
  input logic [SELW-1:0] br_sel,
  input logic [AW-1:0]   ptr,
  input logic [AW-1:0]   ea,
  input logic [AW-1:0]   ptr_nxt,
  input logic            br_act,
  input logic            mod_inh
);
  localparam logic [SELW-1:0] SP = SELW'((1 << SELW) - 1);

  AST_EA_LSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    br_act |-> (ea[0] == 1'b0)); // R6

  AST_INH_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    mod_inh |-> br_act); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(ea) && $stable(ptr_nxt) && $stable(br_act) && $stable(mod_inh))); // R12

  AST_SP_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (br_sel == SP)) |=> !br_act); // R3

  AST_BYTE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !word) |=> !br_act); // R3

  AST_OFS_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (mode == 3'd5)) |=> (ptr_nxt == $past(ptr))); // R9

  AST_PRE_EA: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (mode == 3'd3)) |=> (ea == ptr_nxt)); // R7
endmodule

bind brx_addr_gen brx_addr_gen_chk #(.AW(AW), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .req(req), .word(word), .mode(mode),
  .br_sel(br_sel), .ptr(ptr), .ea(ea), .ptr_nxt(ptr_nxt),
  .br_act(br_act), .mod_inh(mod_inh)
);

// File: tb/brx_addr_gen_tb_top.sv
module brx_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, req, is_write, word, br_en, mod_en;
  logic [2:0]  mode;
  logic [3:0]  reg_idx, br_sel;
  logic [14:0] pivot;
  logic [15:0] ptr, ofs, ea, ptr_nxt;
  logic        br_act, mod_inh;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [15:0] e_ea, e_nx;
  logic        e_act, e_inh;

  brx_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .is_write(is_write), .word(word),
    .mode(mode), .reg_idx(reg_idx), .br_en(br_en), .br_sel(br_sel),
    .mod_en(mod_en), .pivot(pivot), .ptr(ptr), .ofs(ofs),
    .ea(ea), .ptr_nxt(ptr_nxt), .br_act(br_act), .mod_inh(mod_inh)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] m_rc(input logic [15:0] a, input logic [14:0] m);
    logic [15:0] b, r;
    int c, s;
    b = {m, 1'b0};
    a[0] = 1'b0;
    c = 0;
    r = '0;
    for (int i = 15; i >= 0; i--) begin
      s = int'(a[i]) + int'(b[i]) + c;
      r[i] = s[0];
      c = s / 2;
    end
    r[0] = 1'b0;
    return r;
  endfunction

  function automatic int brv(input int k, input int n);
    int r = 0;
    for (int i = 0; i < n; i++) if (((k >> i) & 1) != 0) r |= 1 << (n - 1 - i);
    return r;
  endfunction

  task automatic model();
    bit active;
    int stp;
    logic [15:0] nx;
    active = br_en && (br_sel != 4'd15) && (reg_idx == br_sel) && is_write && word
             && (mode == 3'd1 || mode == 3'd3);
    if (active) begin
      nx = m_rc(ptr, pivot);
      e_nx = nx;
      e_ea = (mode == 3'd3) ? nx : {ptr[15:1], 1'b0};
    end else begin
      stp = word ? 2 : 1;
      case (mode)
        3'd1: begin e_ea = ptr; e_nx = ptr + 16'(stp); end
        3'd2: begin e_ea = ptr; e_nx = ptr - 16'(stp); end
        3'd3: begin e_nx = ptr + 16'(stp); e_ea = e_nx; end
        3'd4: begin e_nx = ptr - 16'(stp); e_ea = e_nx; end
        3'd5: begin e_ea = ptr + ofs; e_nx = ptr; end
        default: begin e_ea = ptr; e_nx = ptr; end
      endcase
    end
    e_act = active;
    e_inh = active && mod_en;
  endtask

  task automatic cmp(input string tag);
    total++;
    if (ea !== e_ea || ptr_nxt !== e_nx || br_act !== e_act || mod_inh !== e_inh) begin
      bad++;
      $display("FAIL %s: actual ea=%h nxt=%h act=%b inh=%b expected ea=%h nxt=%h act=%b inh=%b",
               tag, ea, ptr_nxt, br_act, mod_inh, e_ea, e_nx, e_act, e_inh);
    end
  endtask

  task automatic step(input string tag, input bit rq, input bit wr, input bit wd,
                      input logic [2:0] md, input logic [3:0] ri, input bit en,
                      input logic [3:0] sl, input bit me, input logic [14:0] pv,
                      input logic [15:0] p, input logic [15:0] o);
    req = rq; is_write = wr; word = wd; mode = md; reg_idx = ri; br_en = en;
    br_sel = sl; mod_en = me; pivot = pv; ptr = p; ofs = o;
    if (rq) model();
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic walk(input string tag, input logic [15:0] base, input int n);
    logic [15:0] p, want;
    int pts;
    pts = 1 << n;
    p = base;
    for (int k = 0; k <= pts; k++) begin
      step(tag, 1, 1, 1, 3'd1, 4'd3, 1, 4'd3, 0, 15'(pts / 2), p, 16'h0000);
      want = base + 16'(2 * brv(k % pts, n));
      total++;
      if (ea !== want) begin
        bad++;
        $display("FAIL %s: point %0d actual ea=%h expected ea=%h", tag, k, ea, want);
      end
      p = ptr_nxt;
    end
  endtask

  initial begin
    rst_n = 1'b0; req = 0; is_write = 0; word = 0; mode = 0; reg_idx = 0;
    br_en = 0; br_sel = 0; mod_en = 0; pivot = 0; ptr = 0; ofs = 0;
    e_ea = '0; e_nx = '0; e_act = 0; e_inh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp("R1 reset state");
    step("R1 idle after reset", 0, 1, 1, 3'd1, 4'd3, 1, 4'd3, 1, 15'd4, 16'h0100, 16'h0);

    step("R2 R4 active post-inc", 1, 1, 1, 3'd1, 4'd3, 1, 4'd3, 0, 15'd4, 16'h0100, 16'h0);
    step("R4 large pivot", 1, 1, 1, 3'd1, 4'd5, 1, 4'd5, 0, 15'h4000, 16'h8ABC, 16'h0);
    step("R4 carry chain", 1, 1, 1, 3'd1, 4'd2, 1, 4'd2, 0, 15'd8, 16'h020E, 16'h0);
    step("R5 offset ignored", 1, 1, 1, 3'd1, 4'd3, 1, 4'd3, 0, 15'd4, 16'h0104, 16'h0033);
    step("R6 odd pointer", 1, 1, 1, 3'd1, 4'd3, 1, 4'd3, 0, 15'd4, 16'h0103, 16'h0);
    step("R7 pre-inc active", 1, 1, 1, 3'd3, 4'd3, 1, 4'd3, 0, 15'd4, 16'h0108, 16'h0);
    step("R10 inhibit active", 1, 1, 1, 3'd1, 4'd3, 1, 4'd3, 1, 15'd4, 16'h0108, 16'h0);

    step("R3 enable off", 1, 1, 1, 3'd1, 4'd3, 0, 4'd3, 1, 15'd4, 16'h0100, 16'h0);
    step("R3 stack index", 1, 1, 1, 3'd1, 4'd15, 1, 4'd15, 1, 15'd4, 16'h0100, 16'h0);
    step("R3 other register", 1, 1, 1, 3'd1, 4'd2, 1, 4'd3, 1, 15'd4, 16'h0100, 16'h0);
    step("R3 byte access", 1, 1, 0, 3'd1, 4'd3, 1, 4'd3, 1, 15'd4, 16'h0101, 16'h0);
    step("R3 read access", 1, 0, 1, 3'd1, 4'd3, 1, 4'd3, 1, 15'd4, 16'h0100, 16'h0);
    step("R3 post-dec mode", 1, 1, 1, 3'd2, 4'd3, 1, 4'd3, 1, 15'd4, 16'h0100, 16'h0);
    step("R3 offset mode", 1, 1, 1, 3'd5, 4'd3, 1, 4'd3, 1, 15'd4, 16'h0100, 16'h0010);

    step("R8 post-inc word", 1, 1, 1, 3'd1, 4'd1, 0, 4'd3, 0, 15'd0, 16'h1000, 16'h0);
    step("R8 post-inc byte", 1, 1, 0, 3'd1, 4'd1, 0, 4'd3, 0, 15'd0, 16'h1001, 16'h0);
    step("R8 post-dec word", 1, 1, 1, 3'd2, 4'd1, 0, 4'd3, 0, 15'd0, 16'h0000, 16'h0);
    step("R8 pre-inc byte", 1, 0, 0, 3'd3, 4'd1, 0, 4'd3, 0, 15'd0, 16'hFFFF, 16'h0);
    step("R8 pre-dec word", 1, 1, 1, 3'd4, 4'd1, 0, 4'd3, 0, 15'd0, 16'h2000, 16'h0);
    step("R8 direct", 1, 1, 1, 3'd0, 4'd3, 1, 4'd3, 1, 15'd4, 16'h2345, 16'h0);
    step("R8 code 7", 1, 1, 1, 3'd7, 4'd3, 1, 4'd3, 1, 15'd4, 16'h2346, 16'h0);
    step("R9 offset", 1, 1, 1, 3'd5, 4'd1, 0, 4'd3, 1, 15'd0, 16'h3000, 16'h0124);
    step("R10 no inhibit when normal", 1, 1, 1, 3'd1, 4'd1, 1, 4'd3, 1, 15'd4, 16'h0100, 16'h0);

    step("R12 load", 1, 1, 1, 3'd1, 4'd3, 1, 4'd3, 1, 15'd4, 16'h0100, 16'h0);
    step("R12 hold 1", 0, 1, 1, 3'd4, 4'd1, 0, 4'd3, 0, 15'd0, 16'h7777, 16'h1);
    step("R12 hold 2", 0, 0, 0, 3'd5, 4'd2, 0, 4'd1, 0, 15'd9, 16'h5555, 16'h2);

    walk("R11 8-point", 16'h0100, 3);
    walk("R11 16-point", 16'h0220, 4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule